// File: doc/BRIEF.md
# Overlapped 8-bit Accumulator Microsequencer

This block is a tiny 8-bit accumulator processor core whose state sits entirely in rising-edge flip-flops. It reads program bytes from a memory that returns data one clock after the address is presented. It overlaps the stages of consecutive instructions so that an add-with-carry on an immediate operand costs two effective clocks, although its whole life spans five. The address output is a combinational selection rather than a register. The adder sees the accumulator, the incoming data byte and the carry flag with no register in between. The sum is caught in a result register, and the accumulator is written from that register one clock later, while the next instruction is already being decoded.

Three opcodes are recognised. Add-with-carry immediate is 0x69. Branch-if-minus with an 8-bit signed relative offset is 0x30. No-operation is 0xEA, and every other byte behaves as no-operation too. The sequencer has four named states. FETCH presents the program counter and moves to DECODE. DECODE presents the program counter, examines the opcode on the data input and goes to IMM for 0x69, to BRA0 for 0x30, and back to FETCH for anything else. IMM feeds the operand to the adder, points at the next opcode and returns to DECODE. BRA0 picks the branch target or the next sequential byte from the negative flag and returns to DECODE. Reset puts the sequencer in FETCH.

Top module: `ovl_acc_core`

## Requirements
- R1: While reset is held and in the first cycle after it, the address equals the reset PC (0x0200 by default), and the accumulator, carry and negative outputs are 0.
- R2: In FETCH, DECODE of 0x69 or 0x30, and IMM, the next cycle's address is this cycle's address plus 1.
- R3: A DECODE of any opcode other than 0x69 or 0x30 (0xEA included) keeps the address unchanged for the following cycle, which is a FETCH. Such an opcode takes two cycles.
- R4: For 0x69, with its operand on the data input in cycle k, the accumulator output shows (A + operand + C) mod 256 from cycle k+2, and still shows the old value in cycle k+1.
- R5: After that operand cycle, carry equals bit 8 of A + operand + C and negative equals bit 7 of the sum, both visible from cycle k+1.
- R6: Opcodes 0x30 and 0xEA leave the accumulator, carry and negative unchanged.
- R7: For 0x30 with negative set, the address in the BRA0 cycle is the offset byte's address plus 1 plus the sign-extended offset. The cycle after that presents that target plus 1.
- R8: For 0x30 with negative clear, BRA0 presents the address after the offset byte, so fetching continues in sequence.
- R9: Back-to-back 0x69 instructions each take two cycles with no stall. Each one adds onto the accumulator and carry produced by the one before it.
- R10: A 0x30 placed directly after a 0x69 decides on the negative flag produced by that 0x69.
- R11: Starting from A=0x41 with carry set, adding operand 0x1F leaves the accumulator at 0x61 with carry and negative clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Memory read data, valid one cycle after its address |
| addr | output | 16 | Memory read address (combinational) |
| acc | output | 8 | Accumulator |
| carry | output | 1 | Carry flag |
| negative | output | 1 | Negative flag |

## Verification
The address is due in the same cycle as the state that selects it. The flags are due one cycle after the operand cycle and the accumulator two cycles after it, and the branch target is due in the cycle after the branch opcode is decoded. The bench counts cycles from reset release and samples every output on the falling edge of exactly the counted cycle. A trace test compares every address and latency point against a hand-computed schedule. Sweeps over operand triples and all 256 branch offsets compare the settled values, and the bound checker ties the same latencies to the state.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_IMM    = 2'd2,
        ST_BRA0   = 2'd3
    } seq_state_t;

    localparam logic [7:0] OP_ADC_IMM = 8'h69;
    localparam logic [7:0] OP_BMI     = 8'h30;
    localparam logic [7:0] OP_NOP     = 8'hEA;

endpackage

// File: rtl/ovl_seq.sv
module ovl_seq
    import ovl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    output seq_state_t        state_q,
    output logic              pc_advance,
    output logic              alu_capture,
    output logic              branch_cycle
);

    seq_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: begin
                if (din == DATA_W'(OP_ADC_IMM)) begin
                    state_d = ST_IMM;
                end else if (din == DATA_W'(OP_BMI)) begin
                    state_d = ST_BRA0;
                end else if (din == DATA_W'(OP_NOP)) begin
                    state_d = ST_FETCH;
                end else begin
                    state_d = ST_FETCH;
                end
            end
            ST_IMM:    state_d = ST_DECODE;
            ST_BRA0:   state_d = ST_DECODE;
            default:   state_d = ST_FETCH;
        endcase
    end

    // outputs
    always_comb begin
        pc_advance   = 1'b0;
        alu_capture  = 1'b0;
        branch_cycle = 1'b0;
        unique case (state_q)
            ST_FETCH:  pc_advance = 1'b1;
            ST_DECODE: pc_advance = (din == DATA_W'(OP_ADC_IMM)) ||
                                    (din == DATA_W'(OP_BMI));
            ST_IMM: begin
                pc_advance  = 1'b1;
                alu_capture = 1'b1;
            end
            ST_BRA0: begin
                pc_advance   = 1'b1;
                branch_cycle = 1'b1;
            end
            default: pc_advance = 1'b0;
        endcase
    end

endmodule

// File: rtl/ovl_pc.sv
module ovl_pc #(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] RESET_PC = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_advance,
    input  logic              branch_cycle,
    input  logic              take_branch,
    input  logic [DATA_W-1:0] offset,
    output logic [ADDR_W-1:0] addr
);

    localparam int EXT_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] offset_ext;
    logic [ADDR_W-1:0] target;

    assign offset_ext = {{EXT_W{offset[DATA_W-1]}}, offset};
    assign target     = pc_q + offset_ext;

    // address selection: current PC except for a taken branch
    always_comb begin
        if (branch_cycle && take_branch) begin
            addr = target;
        end else begin
            addr = pc_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else if (pc_advance) begin
            pc_q <= addr + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/ovl_alu.sv
module ovl_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);

    logic [DATA_W:0] wide;

    always_comb begin
        wide = {1'b0, op_a} + {1'b0, op_b} + (DATA_W + 1)'(cin);
        sum  = wide[DATA_W-1:0];
        cout = wide[DATA_W];
    end

endmodule

// File: rtl/ovl_exec.sv
module ovl_exec #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_capture,
    input  logic [DATA_W-1:0] alu_sum,
    input  logic              alu_cout,
    output logic [DATA_W-1:0] acc,
    output logic              carry,
    output logic              negative
);

    logic [DATA_W-1:0] res_q;
    logic              wb_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q    <= '0;
            wb_pend  <= 1'b0;
            acc      <= '0;
            carry    <= 1'b0;
            negative <= 1'b0;
        end else begin
            wb_pend <= alu_capture;
            if (alu_capture) begin
                res_q    <= alu_sum;
                carry    <= alu_cout;
                negative <= alu_sum[DATA_W-1];
            end
            // delayed write overlaps the next instruction's decode
            if (wb_pend) begin
                acc <= res_q;
            end
        end
    end

endmodule

// File: rtl/ovl_acc_core.sv
module ovl_acc_core
    import ovl_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] RESET_PC = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] acc,
    output logic              carry,
    output logic              negative
);

    seq_state_t        state_q;
    logic              pc_advance;
    logic              alu_capture;
    logic              branch_cycle;
    logic [DATA_W-1:0] alu_sum;
    logic              alu_cout;

    ovl_seq #(
        .DATA_W(DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .din         (din),
        .state_q     (state_q),
        .pc_advance  (pc_advance),
        .alu_capture (alu_capture),
        .branch_cycle(branch_cycle)
    );

    ovl_pc #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .RESET_PC(RESET_PC)
    ) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .pc_advance  (pc_advance),
        .branch_cycle(branch_cycle),
        .take_branch (negative),
        .offset      (din),
        .addr        (addr)
    );

    ovl_alu #(
        .DATA_W(DATA_W)
    ) u_alu (
        .op_a(acc),
        .op_b(din),
        .cin (carry),
        .sum (alu_sum),
        .cout(alu_cout)
    );

    ovl_exec #(
        .DATA_W(DATA_W)
    ) u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .alu_capture(alu_capture),
        .alu_sum    (alu_sum),
        .alu_cout   (alu_cout),
        .acc        (acc),
        .carry      (carry),
        .negative   (negative)
    );

endmodule

// File: rtl/ovl_acc_core_chk.sv
module ovl_acc_core_chk
    import ovl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] din,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] acc,
    input logic              carry,
    input logic              negative,
    input seq_state_t        state
);

    logic [DATA_W:0]   ref_sum;
    logic [ADDR_W-1:0] off_ext;

    assign ref_sum = {1'b0, acc} + {1'b0, din} + (DATA_W + 1)'(carry);
    assign off_ext = {{(ADDR_W - DATA_W){din[DATA_W-1]}}, din};

    p_seq_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH || state == ST_IMM) |=> addr == $past(addr) + ADDR_W'(1));

    p_nop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && din != DATA_W'(OP_ADC_IMM) && din != DATA_W'(OP_BMI))
        |=> (state == ST_FETCH && addr == $past(addr)));

    p_acc_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IMM |-> ##2 acc == $past(ref_sum[DATA_W-1:0], 2));

    p_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IMM |=> (carry == $past(ref_sum[DATA_W]) &&
                             negative == $past(ref_sum[DATA_W-1])));

    p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_IMM |=> ($stable(carry) && $stable(negative)));

    p_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRA0 && negative) |-> addr == $past(addr) + ADDR_W'(1) + off_ext);

    p_taken_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_BRA0 |=> addr == $past(addr) + ADDR_W'(1));

    p_not_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRA0 && !negative) |-> addr == $past(addr) + ADDR_W'(1));

endmodule

bind ovl_acc_core ovl_acc_core_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .addr    (addr),
    .acc     (acc),
    .carry   (carry),
    .negative(negative),
    .state   (state_q)
);

// File: tb/ovl_acc_core_tb.sv
module ovl_acc_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [15:0] addr;
    logic [7:0]  acc;
    logic        carry;
    logic        negative;
    logic [7:0]  mem [256];

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    // memory returns data one cycle after the address
    always_ff @(posedge clk) din <= mem[addr[7:0]];

    ovl_acc_core u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .addr    (addr),
        .acc     (acc),
        .carry   (carry),
        .negative(negative)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 8'hEA;
    endtask

    // ends on the falling edge of cycle c0
    task automatic release_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int exp_tr [19];

        // ---- worked example: FF, 42, 1F then BMI not taken ----
        hold_reset();
        mem[0] = 8'h69; mem[1] = 8'hFF; mem[2] = 8'h69; mem[3] = 8'h42;
        mem[4] = 8'h69; mem[5] = 8'h1F; mem[6] = 8'h30; mem[7] = 8'h02;
        release_reset();
        check("R1 reset addr", addr, 16'h0200);
        check("R1 reset acc", acc, 0);
        check("R1 reset carry", carry, 0);
        check("R1 reset negative", negative, 0);
        for (int c = 1; c <= 10; c++) begin
            step(1);
            if (c <= 8) check($sformatf("R2 R8 addr c%0d", c), addr, 16'h0200 + c);
            if (c == 3) check("R5 negative after FF", negative, 1);
            if (c == 3) check("R4 acc not yet written", acc, 0);
            if (c == 4) check("R4 acc after first add", acc, 8'hFF);
            if (c == 5) check("R5 carry after FF+42", carry, 1);
            if (c == 6) check("R9 acc after second add", acc, 8'h41);
            if (c == 7) check("R4 acc one cycle after operand", acc, 8'h41);
            if (c == 7) check("R11 carry", carry, 0);
            if (c == 7) check("R11 negative", negative, 0);
            if (c == 8) check("R11 acc 41+1F+1", acc, 8'h61);
            if (c == 9) check("R3 nop decode addr", addr, 16'h0209);
            if (c == 10) check("R3 nop fetch addr held", addr, 16'h0209);
        end

        // ---- forward and backward branches with NOPs ----
        hold_reset();
        mem[8'h00] = 8'h69; mem[8'h01] = 8'h80; mem[8'h02] = 8'h30; mem[8'h03] = 8'h04;
        mem[8'h04] = 8'h69; mem[8'h05] = 8'h80;
        mem[8'h08] = 8'h69; mem[8'h09] = 8'h00; mem[8'h0A] = 8'h30; mem[8'h0B] = 8'hF8;
        exp_tr = '{16'h0200, 16'h0201, 16'h0202, 16'h0203, 16'h0208, 16'h0209,
                   16'h020A, 16'h020B, 16'h0204, 16'h0205, 16'h0206, 16'h0207,
                   16'h0207, 16'h0208, 16'h0208, 16'h0209, 16'h020A, 16'h020B,
                   16'h020C};
        release_reset();
        for (int c = 0; c <= 18; c++) begin
            if (c > 0) step(1);
            check($sformatf("R2 R3 R7 R8 R10 addr trace c%0d", c), addr, exp_tr[c]);
            if (c == 14) begin
                check("R6 acc across nop", acc, 8'h00);
                check("R6 carry across nop", carry, 1);
                check("R6 negative across nop", negative, 0);
            end
            if (c == 18) begin
                check("R9 acc final", acc, 8'h01);
                check("R10 negative final", negative, 0);
            end
        end

        // ---- reset mid-state clears the core ----
        hold_reset();
        release_reset();
        check("R1 re-reset acc", acc, 0);
        check("R1 re-reset addr", addr, 16'h0200);

        // ---- all branch offsets, both flag states ----
        for (int neg = 0; neg < 2; neg++) begin
            for (int off = 0; off < 256; off++) begin
                logic [15:0] tgt;
                logic [7:0]  v;
                v = neg ? 8'h80 : 8'h05;
                tgt = neg ? 16'(16'h0204 + {{8{off[7]}}, off[7:0]}) : 16'h0204;
                hold_reset();
                mem[0] = 8'h69; mem[1] = v; mem[2] = 8'h30; mem[3] = off[7:0];
                release_reset();
                step(4);
                if (neg) check($sformatf("R7 taken off=%0h", off), addr, tgt);
                else     check($sformatf("R8 not taken off=%0h", off), addr, tgt);
                step(1);
                check($sformatf("R7 R8 after branch off=%0h", off), addr, 16'(tgt + 16'h1));
                check($sformatf("R6 acc over branch off=%0h", off),
                      {acc, carry, negative}, {v, 1'b0, v[7]});
            end
        end

        // ---- sweep of three chained adds ----
        for (int x = 0; x < 256; x += 3) begin
            int ys [6];
            int zs [4];
            ys = '{0, 1, 8'h7F, 8'h80, 8'hC0, 8'hFF};
            zs = '{0, 1, 8'h7F, 8'hFF};
            for (int yi = 0; yi < 6; yi++) begin
                for (int zi = 0; zi < 4; zi++) begin
                    int s2, s3, a2, c2;
                    s2 = x + ys[yi];
                    a2 = s2 & 8'hFF;
                    c2 = s2 >> 8;
                    s3 = a2 + zs[zi] + c2;
                    hold_reset();
                    mem[0] = 8'h69; mem[1] = 8'(x);
                    mem[2] = 8'h69; mem[3] = 8'(ys[yi]);
                    mem[4] = 8'h69; mem[5] = 8'(zs[zi]);
                    release_reset();
                    step(9);
                    check($sformatf("R4 R5 R9 sweep x=%0h y=%0h z=%0h", x, ys[yi], zs[zi]),
                          {acc, carry, negative},
                          {8'(s3), s3[8], s3[7]});
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule